// File: doc/BRIEF.md
# Leading-Zero Anticipating Significand Normalizer

This block is the add/subtract and normalization path of a floating-point adder for 64-bit significands. The two significands arrive already aligned, with a control that selects addition or subtraction. The block returns the magnitude of the result, normalized so that its top bit is set, together with the number of left-shift positions used. The exponent logic subtracts that count. For subtraction it also reports whether the result was negative. An exact zero result has a flag of its own.

The shift count does not come from the finished sum. It is anticipated from the operands alone. Each bit pair is recoded as a signed digit (+1, 0 or -1), which needs no carry. A local three-digit pattern then marks the candidate leading position, and a leading-zero counter turns that into an estimate. For addition the candidate is one place above the top set bit of the OR of the operands. The carry-propagate adder runs in parallel with the estimate. The estimate drives a logarithmic left shifter directly, and zeros fill the vacated low bits. The estimate is never too large and is at most one position short, so one conditional 1-bit shift completes the normalization. The reported count is the estimate plus that correction bit.

The result is a 65-bit frame, so that an addition carry-out needs no right shift. One register stage holds the results. A two-state machine (STG_EMPTY, STG_LOADED) follows the input valid and produces the output valid. Its transitions are: any state to STG_LOADED when `in_valid` is 1, and any state to STG_EMPTY when `in_valid` is 0. Reset is synchronous and active high.

Top module: `lzan_normalizer`

## Requirements
- R1: While `rst` is high at a clock edge, the stage enters STG_EMPTY and every output register clears: `out_valid`, `out_mag`, `out_shift`, `out_neg` and `out_zero` are all 0 after that edge.
- R2: `out_valid` equals `in_valid` from the previous clock edge. When `in_valid` is 0, the data outputs keep their previous values.
- R3: With `in_sub` = 0, the raw result is the 65-bit sum `{0,a} + {0,b}`, and `out_neg` is 0.
- R4: With `in_sub` = 1, the raw result is `|a - b|` as a 65-bit value, and `out_neg` is 1 exactly when b > a.
- R5: For a nonzero raw result, `out_shift` equals the number of leading zeros of the 65-bit raw result, and bit 64 of `out_mag` is 1.
- R6: For a nonzero raw result, `out_mag` equals the raw result shifted left by `out_shift`, with zeros in the low `out_shift` bits.
- R7: A raw result of exactly zero gives `out_zero` = 1 with `out_mag` = 0, `out_shift` = 0 and `out_neg` = 0; otherwise `out_zero` is 0.
- R8: An addition with a carry out of bit 63 gives `out_shift` = 0, and `out_mag` is the full 65-bit sum.
- R9: The largest shift, 64, occurs when `|a - b|` = 1 and yields `out_mag` = 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and control are valid this cycle |
| in_sub | input | 1 | 1 selects a - b, 0 selects a + b |
| in_a | input | 64 | Aligned significand a |
| in_b | input | 64 | Aligned significand b |
| out_valid | output | 1 | Registered result is valid |
| out_mag | output | 65 | Normalized magnitude, top bit set unless zero |
| out_shift | output | 7 | Total left shift applied (estimate plus correction) |
| out_neg | output | 1 | Subtraction result was negative |
| out_zero | output | 1 | Result was exactly zero |

## Verification
Random additions are used to hit both carry-out and no-carry sums. These separate the two places where the addition estimate can land. Random subtractions in which b is a with a random span of its low bits flipped produce heavy cancellation. Long alternating runs of signed digits appear there, and they show whether the anticipated count lands exactly or one short across every shift amount. Directed cases cover a = b, zero operands, differences of 1 in both orders, and an all-ones addition; these pin the zero flag, the 64-position shift, the sign output and the carry-out frame. A gap in `in_valid` shows that the register holds its value and that the valid output follows.

// File: rtl/lzan_pkg.sv
package lzan_pkg;

    localparam int SIG_W_DEF = 64;

    typedef enum logic {
        STG_EMPTY  = 1'b0,
        STG_LOADED = 1'b1
    } stage_e;

endpackage

// File: rtl/lzan_sd_marker.sv
// Carry-free leading-position marker. Each bit pair is recoded as a signed
// digit. A position is marked where the leading nonzero digit can no longer
// be absorbed by the digit below it.
module lzan_sd_marker #(
    parameter int SIG_W = 64,
    localparam int MAG_W = SIG_W + 1
) (
    input  logic             sub,
    input  logic [SIG_W-1:0] a,
    input  logic [SIG_W-1:0] b,
    output logic [MAG_W-1:0] mark
);

    logic [MAG_W-1:0] dpos;
    logic [MAG_W-1:0] dneg;
    logic [MAG_W-1:0] mark_sub;
    logic [MAG_W-1:0] mark_add;

    // Digit string in a 65-position frame; the top digit is always zero.
    assign dpos = {1'b0, a & ~b};
    assign dneg = {1'b0, ~a & b};

    genvar i;
    generate
        for (i = 0; i < MAG_W; i++) begin : g_pos
            logic up_nz;
            logic lo_pos;
            logic lo_neg;
            logic stop_head;
            logic stop_run;
            if (i == MAG_W - 1) begin : g_top
                assign up_nz = 1'b0;
            end else begin : g_mid
                assign up_nz = dpos[i+1] | dneg[i+1];
            end
            if (i == 0) begin : g_lsb
                assign lo_pos = 1'b0;
                assign lo_neg = 1'b0;
            end else begin : g_rest
                assign lo_pos = dpos[i-1];
                assign lo_neg = dneg[i-1];
            end
            // Head digit: keep looking lower only while the next digit has the opposite sign.
            assign stop_head = (dpos[i] & ~lo_neg) | (dneg[i] & ~lo_pos);
            // Inside a collapsing run: keep looking lower only while the next digit repeats.
            assign stop_run  = (dpos[i] & ~lo_pos) | (dneg[i] & ~lo_neg);
            assign mark_sub[i] = up_nz ? stop_run : stop_head;
        end
    endgenerate

    // Addition: the leading one is at most one place above the top set bit of a|b.
    assign mark_add = {a | b, 1'b0};

    assign mark = sub ? mark_sub : mark_add;

endmodule

// File: rtl/lzan_lzc.sv
// Leading-zero counter; an all-zero input returns WIDTH.
module lzan_lzc #(
    parameter int WIDTH = 65,
    localparam int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] vec,
    output logic [CNT_W-1:0] count
);

    always_comb begin
        count = CNT_W'(WIDTH);
        for (int i = 0; i < WIDTH; i++) begin
            if (vec[i]) begin
                count = CNT_W'(WIDTH - 1 - i);
            end
        end
    end

endmodule

// File: rtl/lzan_mag_adder.sv
// Carry-propagate add or subtract, returning the magnitude and its sign.
module lzan_mag_adder #(
    parameter int SIG_W = 64,
    localparam int MAG_W = SIG_W + 1
) (
    input  logic             sub,
    input  logic [SIG_W-1:0] a,
    input  logic [SIG_W-1:0] b,
    output logic [MAG_W-1:0] mag,
    output logic             neg
);

    logic [MAG_W:0]   diff;
    logic [MAG_W-1:0] sum;

    assign sum  = {1'b0, a} + {1'b0, b};
    assign diff = {2'b00, a} - {2'b00, b};

    always_comb begin
        if (sub) begin
            neg = diff[MAG_W];
            mag = diff[MAG_W] ? (~diff[MAG_W-1:0] + MAG_W'(1)) : diff[MAG_W-1:0];
        end else begin
            neg = 1'b0;
            mag = sum;
        end
    end

endmodule

// File: rtl/lzan_norm_shifter.sv
// Logarithmic left shifter driven by the estimate, then a 1-bit correction.
module lzan_norm_shifter #(
    parameter int MAG_W = 65,
    localparam int SH_W = $clog2(MAG_W + 1)
) (
    input  logic [MAG_W-1:0] raw,
    input  logic [SH_W-1:0]  est,
    output logic [MAG_W-1:0] norm,
    output logic             fix
);

    logic [MAG_W-1:0] stage [0:SH_W];

    assign stage[0] = raw;

    genvar s;
    generate
        for (s = 0; s < SH_W; s++) begin : g_stage
            localparam int AMT = 1 << s;
            if (AMT < MAG_W) begin : g_shift
                assign stage[s+1] = est[s] ? {stage[s][MAG_W-1-AMT:0], {AMT{1'b0}}} : stage[s];
            end else begin : g_clear
                assign stage[s+1] = est[s] ? '0 : stage[s];
            end
        end
    endgenerate

    assign fix  = ~stage[SH_W][MAG_W-1];
    assign norm = fix ? {stage[SH_W][MAG_W-2:0], 1'b0} : stage[SH_W];

endmodule

// File: rtl/lzan_normalizer.sv
module lzan_normalizer
    import lzan_pkg::*;
#(
    parameter int SIG_W = SIG_W_DEF,
    localparam int MAG_W = SIG_W + 1,
    localparam int SH_W = $clog2(MAG_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sub,
    input  logic [SIG_W-1:0] in_a,
    input  logic [SIG_W-1:0] in_b,
    output logic             out_valid,
    output logic [MAG_W-1:0] out_mag,
    output logic [SH_W-1:0]  out_shift,
    output logic             out_neg,
    output logic             out_zero
);

    logic [MAG_W-1:0] mark;
    logic [SH_W-1:0]  est;
    logic [MAG_W-1:0] raw;
    logic             raw_neg;
    logic [MAG_W-1:0] norm;
    logic             fix;
    logic             raw_zero;
    logic [SH_W-1:0]  tot_shift;

    stage_e state_q;
    stage_e state_d;

    // Estimate path, built from the operands only.
    lzan_sd_marker #(.SIG_W(SIG_W)) u_marker (
        .sub  (in_sub),
        .a    (in_a),
        .b    (in_b),
        .mark (mark)
    );

    lzan_lzc #(.WIDTH(MAG_W)) u_lzc (
        .vec   (mark),
        .count (est)
    );

    // Carry-propagate path, in parallel with the estimate.
    lzan_mag_adder #(.SIG_W(SIG_W)) u_adder (
        .sub (in_sub),
        .a   (in_a),
        .b   (in_b),
        .mag (raw),
        .neg (raw_neg)
    );

    lzan_norm_shifter #(.MAG_W(MAG_W)) u_shift (
        .raw  (raw),
        .est  (est),
        .norm (norm),
        .fix  (fix)
    );

    assign raw_zero  = (raw == '0);
    assign tot_shift = raw_zero ? '0 : (est + SH_W'(fix));

    // Stage state register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= STG_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STG_EMPTY:  state_d = in_valid ? STG_LOADED : STG_EMPTY;
            STG_LOADED: state_d = in_valid ? STG_LOADED : STG_EMPTY;
            default:    state_d = STG_EMPTY;
        endcase
    end

    assign out_valid = (state_q == STG_LOADED);

    // Result registers, loaded only with valid input.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_mag   <= '0;
            out_shift <= '0;
            out_neg   <= 1'b0;
            out_zero  <= 1'b0;
        end else if (in_valid) begin
            out_mag   <= raw_zero ? '0 : norm;
            out_shift <= tot_shift;
            out_neg   <= raw_zero ? 1'b0 : raw_neg;
            out_zero  <= raw_zero;
        end
    end

endmodule

// File: rtl/lzan_normalizer_chk.sv
module lzan_normalizer_chk #(
    parameter int SIG_W = 64,
    localparam int MAG_W = SIG_W + 1,
    localparam int SH_W = $clog2(MAG_W + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_sub,
    input logic             out_valid,
    input logic [MAG_W-1:0] out_mag,
    input logic [SH_W-1:0]  out_shift,
    input logic             out_neg,
    input logic             out_zero
);

    logic low_clear;

    always_comb begin
        low_clear = 1'b1;
        for (int i = 0; i < MAG_W; i++) begin
            if ((i < int'(out_shift)) && out_mag[i]) begin
                low_clear = 1'b0;
            end
        end
    end

    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_drop_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_mag) && $stable(out_shift) && $stable(out_neg) && $stable(out_zero)));

    assert_add_sign_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_sub) |=> !out_neg);

    assert_normalized_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_zero) |-> (out_mag[MAG_W-1] && int'(out_shift) < MAG_W));

    assert_zero_fill_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_zero) |-> low_clear);

    assert_zero_result_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_zero) |-> (out_mag == '0 && out_shift == '0 && !out_neg));

endmodule

bind lzan_normalizer lzan_normalizer_chk #(.SIG_W(SIG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sub    (in_sub),
    .out_valid (out_valid),
    .out_mag   (out_mag),
    .out_shift (out_shift),
    .out_neg   (out_neg),
    .out_zero  (out_zero)
);

// File: tb/lzan_normalizer_tb.sv
module lzan_normalizer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 64;
    localparam int MW = W + 1;
    localparam int SW = 7;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic          in_sub;
    logic [W-1:0]  in_a;
    logic [W-1:0]  in_b;
    logic          out_valid;
    logic [MW-1:0] out_mag;
    logic [SW-1:0] out_shift;
    logic          out_neg;
    logic          out_zero;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lzan_normalizer u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sub    (in_sub),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_mag   (out_mag),
        .out_shift (out_shift),
        .out_neg   (out_neg),
        .out_zero  (out_zero)
    );

    task automatic check(input bit ok, input string req, input logic [MW-1:0] act,
                         input logic [MW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [MW-1:0] ref_raw(input logic [W-1:0] a, input logic [W-1:0] b,
                                              input logic sub);
        if (!sub) return {1'b0, a} + {1'b0, b};
        return (a >= b) ? {1'b0, a - b} : {1'b0, b - a};
    endfunction

    function automatic int ref_lz(input logic [MW-1:0] v);
        for (int i = MW - 1; i >= 0; i--) begin
            if (v[i]) return MW - 1 - i;
        end
        return 0;
    endfunction

    task automatic run_vec(input logic [W-1:0] a, input logic [W-1:0] b, input logic sub,
                           input string tag);
        logic [MW-1:0] raw;
        logic [MW-1:0] emag;
        int            esh;
        logic          eneg;
        logic          ezero;
        raw   = ref_raw(a, b, sub);
        ezero = (raw == '0);
        esh   = ezero ? 0 : ref_lz(raw);
        emag  = ezero ? '0 : (raw << esh);
        eneg  = sub && (b > a);
        @(negedge clk);
        in_valid = 1'b1;
        in_sub   = sub;
        in_a     = a;
        in_b     = b;
        @(negedge clk);
        check(out_valid === 1'b1, {tag, " R2 valid"}, MW'(out_valid), MW'(1));
        check(out_mag === emag, {tag, " R6 mag"}, out_mag, emag);
        check(int'(out_shift) == esh, {tag, " R5 shift"}, MW'(out_shift), MW'(esh));
        check(out_neg === eneg, {tag, sub ? " R4 neg" : " R3 neg"}, MW'(out_neg), MW'(eneg));
        check(out_zero === ezero, {tag, " R7 zero"}, MW'(out_zero), MW'(ezero));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [MW-1:0] held_mag;
        logic [SW-1:0] held_shift;
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; in_sub = 1'b0; in_a = '0; in_b = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid === 1'b0, "R1 valid", MW'(out_valid), MW'(0));
        check(out_mag === '0, "R1 mag", out_mag, '0);
        check(out_shift === '0 && out_neg === 1'b0 && out_zero === 1'b0, "R1 flags",
              MW'({out_shift, out_neg, out_zero}), '0);
        rst = 1'b0;

        // Directed corners
        run_vec(64'h1234, 64'h1234, 1'b1, "R7 sub equal");
        run_vec('0, '0, 1'b0, "R7 add zero");
        run_vec('1, 64'd1, 1'b0, "R8 carry out");
        run_vec(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, "R8 carry top");
        run_vec(64'd5, 64'd4, 1'b1, "R9 diff one");
        run_vec(64'd4, 64'd5, 1'b1, "R9 diff one neg");
        run_vec(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, "R9 borrow run");
        run_vec(64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b1, "R4 borrow run neg");
        run_vec(64'd1, 64'd0, 1'b0, "R3 tiny add");
        run_vec(64'h0000_0001_0000_0000, 64'h0000_0000_FFFF_FFFF, 1'b0, "R3 no carry");
        run_vec(64'hC000_0000_0000_0000, 64'h4000_0000_0000_0001, 1'b1, "R4 mid cancel");

        // R2: a gap in in_valid, outputs held
        held_mag   = out_mag;
        held_shift = out_shift;
        @(negedge clk);
        in_valid = 1'b0;
        in_a     = '1;
        in_b     = 64'd3;
        in_sub   = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R2 valid drop", MW'(out_valid), MW'(0));
        check(out_mag === held_mag && out_shift === held_shift, "R2 hold", out_mag, held_mag);

        // Random additions
        for (int n = 0; n < 300; n++) begin
            a = {$urandom, $urandom} >> ($urandom % 64);
            b = {$urandom, $urandom} >> ($urandom % 64);
            run_vec(a, b, 1'b0, "R3 rand add");
        end
        // Random subtractions with heavy cancellation
        for (int n = 0; n < 600; n++) begin
            a = {$urandom, $urandom};
            if (n % 3 == 0) b = {$urandom, $urandom} >> ($urandom % 64);
            else b = a ^ ({$urandom, $urandom} >> ($urandom % 64));
            run_vec(a, b, 1'b1, "R4 rand sub");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule